// File: doc/BRIEF.md
# Expansion Slot Address Decoder

This block sits between a host expansion port and a backplane of eight card slots. The host opens a 128-location I/O window by pulling an active-low window-select line low. While the window is open, the seven address bits are split into two fields. The lower four bits pick one of sixteen register strobes, and these strobes are wired in parallel to every slot. The upper three bits pick one of eight slot selects, and each of these goes to a single slot.

A card qualifies a shared register strobe with its own slot select. Because the register field means the same thing in every slot, a card works in any slot, and software only needs to know which slot the card is in. The host read/write line reaches each slot in both true and inverted form. A card can then build a qualified strobe of either polarity without an inverter of its own.

The decode is purely combinational and adds no register stage. Internally it follows the classic active-low decoder. The slot field is padded up to the width of a 16-way decoder, with its top select bit held at zero. Both decoders are then inverted so that every output is active high.

Top module: `expslot_decode`

## Requirements
- R1: While `win_n` is 1, every bit of `strobe` and every bit of `slot_sel` is 0, whatever the value on `addr`.
- R2: While `win_n` is 0, `strobe` has exactly one bit set, at index `addr[3:0]` (bit 0 for offset 0, bit 15 for offset 15).
- R3: While `win_n` is 0, `slot_sel` has exactly one bit set, at index `addr[6:4]` (bit 0 for window offsets 0x00–0x0F, bit 7 for 0x70–0x7F).
- R4: Every bit of `rw` equals `host_rw`, and every bit of `rw_n` equals its inverse, for any value of `win_n` and `addr`. A value of 1 on `host_rw` means a read cycle.
- R5: The register strobe picked depends only on `addr[3:0]`. Changing `addr[6:4]` with `win_n` at 0 moves only `slot_sel` and leaves `strobe` unchanged.
- R6: The outputs follow the inputs with no clock and no added latency. New outputs are valid in the same cycle in which `win_n`, `addr` or `host_rw` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| win_n | input | 1 | Window select from the host, active low; enables the whole decode |
| addr | input | 7 | Offset within the 128-location window |
| host_rw | input | 1 | Host read/write line, 1 = read |
| strobe | output | 16 | Register strobes shared by all slots, active high, one-hot when enabled |
| slot_sel | output | 8 | Per-slot selects, active high, one-hot when enabled |
| rw | output | 8 | True read/write copy for each slot |
| rw_n | output | 8 | Inverted read/write copy for each slot |

## Verification
The hardest cases to reach are the edges of the two fields, where an off-by-one or a mis-padded slot field would fire the wrong strobe or a phantom ninth slot. These are offsets 0x0F/0x10 and 0x6F/0x70, and the all-ones offset 0x7F. The stimulus sweeps all 128 offsets, once with the window closed and once with it open, and toggles `host_rw` along the way. It then adds a block of seeded random vectors. These mix quick window toggles with upper-field changes at a fixed register offset, so that the independence of the shared strobe from the slot field is observed directly.

// File: rtl/expslot_pkg.sv
package expslot_pkg;
   localparam int unsigned REG_FIELD_W  = 4;
   localparam int unsigned SLOT_FIELD_W = 3;
   localparam int unsigned SLOT_DEC_W   = 4;
   localparam int unsigned WIN_ADDR_W   = REG_FIELD_W + SLOT_FIELD_W;
   localparam int unsigned NUM_REGS     = 1 << REG_FIELD_W;
   localparam int unsigned NUM_SLOTS    = 1 << SLOT_FIELD_W;

   typedef enum logic {
      DEC_COMPARE = 1'b0,
      DEC_SHIFT   = 1'b1
   } dec_style_e;
endpackage

// File: rtl/expslot_onehot_dec.sv
module expslot_onehot_dec
   import expslot_pkg::*;
#(
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned NUM_OUT = 16,
   parameter dec_style_e  STYLE   = DEC_SHIFT
) (
   input  logic               en_n,
   input  logic [SEL_W-1:0]   sel,
   output logic [NUM_OUT-1:0] out_n
);
   localparam int unsigned FULL_OUT = 1 << SEL_W;

   if (NUM_OUT > FULL_OUT) begin : g_bad_count
      $error("expslot_onehot_dec: NUM_OUT exceeds 2**SEL_W");
   end
   if (NUM_OUT < 2) begin : g_bad_small
      $error("expslot_onehot_dec: NUM_OUT must be at least 2");
   end

   logic [NUM_OUT-1:0] hot;

   if (STYLE == DEC_SHIFT) begin : g_shift
      localparam logic [NUM_OUT-1:0] ONE = {{(NUM_OUT-1){1'b0}}, 1'b1};
      always_comb begin
         if (en_n) hot = '0;
         else      hot = ONE << sel;
      end
   end else begin : g_compare
      for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
         assign hot[g] = !en_n && (sel == SEL_W'(g));
      end
   end

   // active-low outputs, as on a classic decoder part
   assign out_n = ~hot;
endmodule

// File: rtl/expslot_rw_fanout.sv
module expslot_rw_fanout #(
   parameter int unsigned NUM_SLOTS = 8
) (
   input  logic                 host_rw,
   output logic [NUM_SLOTS-1:0] rw,
   output logic [NUM_SLOTS-1:0] rw_n
);
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("expslot_rw_fanout: NUM_SLOTS must be at least 1");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign rw[s]   = host_rw;
      assign rw_n[s] = ~host_rw;
   end
endmodule

// File: rtl/expslot_decode.sv
module expslot_decode
   import expslot_pkg::*;
#(
   parameter int unsigned REG_W     = REG_FIELD_W,
   parameter int unsigned SLOT_W    = SLOT_FIELD_W,
   parameter int unsigned SLOT_DW   = SLOT_DEC_W,
   parameter dec_style_e  REG_STYLE = DEC_SHIFT,
   parameter dec_style_e  SLT_STYLE = DEC_COMPARE,
   localparam int unsigned AW       = REG_W + SLOT_W,
   localparam int unsigned NREG     = 1 << REG_W,
   localparam int unsigned NSLOT    = 1 << SLOT_W
) (
   input  logic             win_n,
   input  logic [AW-1:0]    addr,
   input  logic             host_rw,
   output logic [NREG-1:0]  strobe,
   output logic [NSLOT-1:0] slot_sel,
   output logic [NSLOT-1:0] rw,
   output logic [NSLOT-1:0] rw_n
);
   if (SLOT_DW < SLOT_W) begin : g_bad_slot_dec
      $error("expslot_decode: slot decoder narrower than slot field");
   end
   if (REG_W < 1 || SLOT_W < 1) begin : g_bad_fields
      $error("expslot_decode: address fields must be at least one bit");
   end

   logic [REG_W-1:0]   reg_field;
   logic [SLOT_DW-1:0] slot_field;
   logic [NREG-1:0]    strobe_lo;
   logic [NSLOT-1:0]   slot_lo;

   assign reg_field = addr[REG_W-1:0];

   // slot field padded up to decoder width with top select bits at zero
   if (SLOT_DW > SLOT_W) begin : g_pad
      assign slot_field = {{(SLOT_DW-SLOT_W){1'b0}}, addr[AW-1:REG_W]};
   end else begin : g_nopad
      assign slot_field = addr[AW-1:REG_W];
   end

   expslot_onehot_dec #(
      .SEL_W   (REG_W),
      .NUM_OUT (NREG),
      .STYLE   (REG_STYLE)
   ) u_reg_dec (
      .en_n  (win_n),
      .sel   (reg_field),
      .out_n (strobe_lo)
   );

   expslot_onehot_dec #(
      .SEL_W   (SLOT_DW),
      .NUM_OUT (NSLOT),
      .STYLE   (SLT_STYLE)
   ) u_slot_dec (
      .en_n  (win_n),
      .sel   (slot_field),
      .out_n (slot_lo)
   );

   // inversion stage: active-high strobes and selects
   for (genvar r = 0; r < NREG; r++) begin : g_reg_inv
      assign strobe[r] = ~strobe_lo[r];
   end
   for (genvar s = 0; s < NSLOT; s++) begin : g_slot_inv
      assign slot_sel[s] = ~slot_lo[s];
   end

   expslot_rw_fanout #(
      .NUM_SLOTS (NSLOT)
   ) u_rw (
      .host_rw (host_rw),
      .rw      (rw),
      .rw_n    (rw_n)
   );
endmodule

// File: rtl/expslot_decode_chk.sv
module expslot_decode_chk #(
   parameter int unsigned AW    = 7,
   parameter int unsigned REG_W = 4,
   parameter int unsigned NREG  = 16,
   parameter int unsigned NSLOT = 8
) (
   input logic             win_n,
   input logic [AW-1:0]    addr,
   input logic             host_rw,
   input logic [NREG-1:0]  strobe,
   input logic [NSLOT-1:0] slot_sel,
   input logic [NSLOT-1:0] rw,
   input logic [NSLOT-1:0] rw_n
);
   always_comb begin
      if (win_n === 1'b1) begin
         // R1
         strobe_idle_chk: assert (strobe == '0);
         // R1
         slot_idle_chk: assert (slot_sel == '0);
      end
      if (win_n === 1'b0 && !$isunknown(addr)) begin
         // R2
         strobe_onehot_chk: assert ($countones(strobe) == 1 && strobe[addr[REG_W-1:0]]);
         // R3
         slot_onehot_chk: assert ($countones(slot_sel) == 1 && slot_sel[addr[AW-1:REG_W]]);
      end
      if (!$isunknown(host_rw)) begin
         // R4
         rw_true_chk: assert (rw == {NSLOT{host_rw}});
         // R4
         rw_inv_chk: assert ((rw ^ rw_n) == {NSLOT{1'b1}});
      end
   end
endmodule

bind expslot_decode expslot_decode_chk #(
   .AW    (AW),
   .REG_W (REG_W),
   .NREG  (NREG),
   .NSLOT (NSLOT)
) u_chk (
   .win_n    (win_n),
   .addr     (addr),
   .host_rw  (host_rw),
   .strobe   (strobe),
   .slot_sel (slot_sel),
   .rw       (rw),
   .rw_n     (rw_n)
);

// File: tb/expslot_decode_bench.sv
`timescale 1ns/1ps
module expslot_decode_bench;
   logic       clk = 1'b0;
   logic       win_n = 1'b1;
   logic [6:0] addr = '0;
   logic       host_rw = 1'b0;
   logic [15:0] strobe;
   logic [7:0]  slot_sel, rw, rw_n;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   expslot_decode u_expslot_decode (
      .win_n(win_n), .addr(addr), .host_rw(host_rw),
      .strobe(strobe), .slot_sel(slot_sel), .rw(rw), .rw_n(rw_n)
   );

   function automatic logic [15:0] exp_strobe(logic w, logic [6:0] a);
      return w ? 16'h0 : (16'h1 << a[3:0]);
   endfunction
   function automatic logic [7:0] exp_slot(logic w, logic [6:0] a);
      return w ? 8'h0 : (8'h1 << a[6:4]);
   endfunction

   task automatic cmp16(string req, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: win_n=%b addr=%h actual=%h expected=%h", req, win_n, addr, act, exp);
      end
   endtask

   // drive at posedge, check at the following negedge (same cycle: R6)
   task automatic apply(logic w, logic [6:0] a, logic r);
      @(posedge clk);
      win_n = w; addr = a; host_rw = r;
      @(negedge clk);
      cmp16(w ? "R1" : "R2", strobe, exp_strobe(w, a));
      cmp16(w ? "R1" : "R3", {8'h0, slot_sel}, {8'h0, exp_slot(w, a)});
      cmp16("R4", {8'h0, rw}, {8'h0, {8{r}}});
      cmp16("R4", {8'h0, rw_n}, {8'h0, {8{~r}}});
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      // reset state: window closed, R1
      cmp16("R1", strobe, 16'h0);
      cmp16("R1", {8'h0, slot_sel}, 16'h0);
      // full sweeps, closed then open
      for (int w = 1; w >= 0; w--) begin
         for (int a = 0; a < 128; a++) begin
            apply(w[0], a[6:0], a[0] ^ a[4]);
         end
      end
      // field boundary corners
      apply(1'b0, 7'h0F, 1'b1);
      apply(1'b0, 7'h10, 1'b0);
      apply(1'b0, 7'h6F, 1'b1);
      apply(1'b0, 7'h70, 1'b0);
      apply(1'b0, 7'h7F, 1'b1);
      apply(1'b1, 7'h7F, 1'b1);
      // R5: upper field sweep at fixed register offset
      for (int s = 0; s < 8; s++) begin
         apply(1'b0, {s[2:0], 4'h9}, 1'b1);
         cmp16("R5", strobe, 16'h0200);
      end
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         apply(rv[9:8] == 2'b00, rv[6:0], rv[12]);
      end
      // R5: change upper field while open, strobe held
      for (int i = 0; i < 20; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         apply(1'b0, rv[6:0], rv[7]);
         held = strobe;
         apply(1'b0, {rv[10:8], rv[3:0]}, rv[7]);
         cmp16("R5", strobe, held);
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule